// File: doc/BRIEF.md
# Register Port and Operand Source Selector

This block is the decode-side steering logic of a sequential processor core. From the instruction class code (`icode`), the two register fields of the instruction and the condition result that the condition logic has already worked out, it picks which register identifiers drive the two register file read ports and the two write ports. It also produces select codes for the ALU operand multiplexers and for the next-PC multiplexer. The block is purely combinational, so its outputs follow its inputs within the same cycle.

Every register identifier is 4 bits wide. The all-ones value (0xF) means "no register": a read port with that value is unused, and a write port with that value performs no write. Stack instructions ignore the second register field. They aim the relevant ports at the stack pointer instead, which is register 4 by default. A register pop writes two registers. A conditional move drops its write when its condition is false.

Instruction class codes, as decoded here: 0 halt, 1 nop, 2 register move / conditional move, 3 immediate-to-register move, 4 register-to-memory store, 5 memory-to-register load, 6 integer operation, 7 jump, 8 call, 9 return, A push, B pop. The codes C through F are invalid. In the requirements, "none" means 0xF and "SP" means the stack pointer identifier. ALU A select: 0 valA, 1 valC, 2 constant +4, 3 constant -4, 4 zero. ALU B select: 0 valB, 1 zero. Next-PC select: 0 valP, 1 valC, 2 valM.

Top module: `regport_select`

## Requirements
- R1: For icode 6 the outputs are src_a=rA, src_b=rB, dst_e=rB, dst_m=none, ALU A=0 (valA), ALU B=0 (valB) and next-PC=0 (valP).
- R2: For icode 2 the outputs are src_a=rA, src_b=none, dst_m=none, ALU A=0, ALU B=1 (zero) and next-PC=0. dst_e is rB when cnd is 1 and none when cnd is 0.
- R3: For icode 3 the outputs are src_a=none, src_b=none, dst_e=rB, dst_m=none, ALU A=1 (valC), ALU B=1 and next-PC=0.
- R4: For icode 4 the outputs are src_a=rA, src_b=rB and no writes. For icode 5 they are src_a=none, src_b=rB, dst_e=none and dst_m=rA. Both codes use ALU A=1, ALU B=0 and next-PC=0.
- R5: For icode A the outputs are src_a=rA, src_b=SP, dst_e=SP, dst_m=none, ALU A=3 (-4), ALU B=0 and next-PC=0. For icode 8 they are src_a=none, src_b=SP, dst_e=SP, dst_m=none, ALU A=3, ALU B=0 and next-PC=1 (valC).
- R6: For icode B the outputs are src_a=SP, src_b=SP, dst_e=SP, dst_m=rA, ALU A=2 (+4), ALU B=0 and next-PC=0. When rA equals SP, dst_e is none, so that the loaded value alone lands in the stack pointer.
- R7: For icode 9 the outputs are src_a=SP, src_b=SP, dst_e=SP, dst_m=none, ALU A=2, ALU B=0 and next-PC=2 (valM).
- R8: For icode 7 all four ports are none and both ALU selects are zero (A=4, B=1). Next-PC is 1 when cnd is 1 and 0 when cnd is 0.
- R9: For icodes 0, 1 and C through F all four ports are none, ALU A=4, ALU B=1 and next-PC=0, whatever the values of rA, rB and cnd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| icode_i | input | 4 | Instruction class code |
| ra_i | input | 4 | First register field of the instruction |
| rb_i | input | 4 | Second register field of the instruction |
| cnd_i | input | 1 | Condition result for a jump or conditional move |
| src_a_o | output | 4 | Register file read port A identifier (0xF = unused) |
| src_b_o | output | 4 | Register file read port B identifier (0xF = unused) |
| dst_e_o | output | 4 | Write port for the ALU result (0xF = no write) |
| dst_m_o | output | 4 | Write port for the memory result (0xF = no write) |
| alu_a_sel_o | output | 3 | ALU operand A source select |
| alu_b_sel_o | output | 1 | ALU operand B source select |
| pc_sel_o | output | 2 | Next-PC source select |

## Verification
The bench builds the block with its default parameters: 4-bit register identifiers and the stack pointer at register 4. With these values a pop whose rA is 4 is reachable, so the bench can observe the write-collision rule. The bench sweeps all sixteen class codes against register fields that include 0, 4 and 0xF, with both condition values. This covers the invalid codes and shows that the stack classes ignore rB while the non-stack classes pass every register field through unchanged.

// File: rtl/regsel_pkg.sv
package regsel_pkg;

  localparam int ICODE_W = 4;

  // instruction class codes (fixed: produced by the fetch stage)
  localparam logic [ICODE_W-1:0] IC_HALT  = 4'h0;
  localparam logic [ICODE_W-1:0] IC_NOP   = 4'h1;
  localparam logic [ICODE_W-1:0] IC_CMOV  = 4'h2;
  localparam logic [ICODE_W-1:0] IC_IRMOV = 4'h3;
  localparam logic [ICODE_W-1:0] IC_STORE = 4'h4;
  localparam logic [ICODE_W-1:0] IC_LOAD  = 4'h5;
  localparam logic [ICODE_W-1:0] IC_ALU   = 4'h6;
  localparam logic [ICODE_W-1:0] IC_JUMP  = 4'h7;
  localparam logic [ICODE_W-1:0] IC_CALL  = 4'h8;
  localparam logic [ICODE_W-1:0] IC_RET   = 4'h9;
  localparam logic [ICODE_W-1:0] IC_PUSH  = 4'hA;
  localparam logic [ICODE_W-1:0] IC_POP   = 4'hB;

  typedef enum logic [2:0] {
    OPA_VALA = 3'd0,
    OPA_VALC = 3'd1,
    OPA_INC4 = 3'd2,
    OPA_DEC4 = 3'd3,
    OPA_ZERO = 3'd4
  } opa_sel_e;

  typedef enum logic {
    OPB_VALB = 1'b0,
    OPB_ZERO = 1'b1
  } opb_sel_e;

  typedef enum logic [1:0] {
    NPC_SEQ  = 2'd0,
    NPC_VALC = 2'd1,
    NPC_VALM = 2'd2
  } npc_sel_e;

endpackage

// File: rtl/regsel_src.sv
module regsel_src
  import regsel_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int SP_ID = 4
) (
  input  logic [ICODE_W-1:0] icode_i,
  input  logic [REG_W-1:0]   ra_i,
  input  logic [REG_W-1:0]   rb_i,
  output logic [REG_W-1:0]   src_a_o,
  output logic [REG_W-1:0]   src_b_o
);

  localparam logic [REG_W-1:0] NONE = '1;
  localparam logic [REG_W-1:0] SP   = REG_W'(SP_ID);

  // read port A: explicit rA users, or the stack pointer for stack pops
  always_comb begin
    src_a_o = NONE;
    case (icode_i)
      IC_CMOV, IC_STORE, IC_ALU, IC_PUSH: src_a_o = ra_i;
      IC_POP, IC_RET:                     src_a_o = SP;
      default:                            src_a_o = NONE;
    endcase
  end

  // read port B: base/second operand, or the stack pointer for all stack classes
  always_comb begin
    src_b_o = NONE;
    case (icode_i)
      IC_ALU, IC_STORE, IC_LOAD:          src_b_o = rb_i;
      IC_PUSH, IC_POP, IC_CALL, IC_RET:   src_b_o = SP;
      default:                            src_b_o = NONE;
    endcase
  end

endmodule

// File: rtl/regsel_dst.sv
module regsel_dst
  import regsel_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int SP_ID = 4
) (
  input  logic [ICODE_W-1:0] icode_i,
  input  logic [REG_W-1:0]   ra_i,
  input  logic [REG_W-1:0]   rb_i,
  input  logic               cnd_i,
  output logic [REG_W-1:0]   dst_e_o,
  output logic [REG_W-1:0]   dst_m_o
);

  localparam logic [REG_W-1:0] NONE = '1;
  localparam logic [REG_W-1:0] SP   = REG_W'(SP_ID);

  logic pop_hits_sp;
  assign pop_hits_sp = (ra_i == SP);

  always_comb begin
    dst_e_o = NONE;
    case (icode_i)
      IC_CMOV:                   dst_e_o = cnd_i ? rb_i : NONE;
      IC_IRMOV, IC_ALU:          dst_e_o = rb_i;
      IC_PUSH, IC_CALL, IC_RET:  dst_e_o = SP;
      IC_POP:                    dst_e_o = pop_hits_sp ? NONE : SP;
      default:                   dst_e_o = NONE;
    endcase
  end

  always_comb begin
    dst_m_o = NONE;
    case (icode_i)
      IC_LOAD, IC_POP: dst_m_o = ra_i;
      default:         dst_m_o = NONE;
    endcase
  end

  // both write ports never aim at one register (memory result wins)
  always_comb begin
    if (dst_e_o != NONE) begin
      p_single_target_r6: assert (dst_e_o != dst_m_o)
        else $error("two write ports target register %0h", dst_e_o);
    end
  end

endmodule

// File: rtl/regsel_flow.sv
module regsel_flow
  import regsel_pkg::*;
(
  input  logic [ICODE_W-1:0] icode_i,
  input  logic               cnd_i,
  output opa_sel_e           opa_o,
  output opb_sel_e           opb_o,
  output npc_sel_e           npc_o
);

  always_comb begin
    opa_o = OPA_ZERO;
    opb_o = OPB_ZERO;
    case (icode_i)
      IC_ALU:            begin opa_o = OPA_VALA; opb_o = OPB_VALB; end
      IC_CMOV:           begin opa_o = OPA_VALA; opb_o = OPB_ZERO; end
      IC_IRMOV:          begin opa_o = OPA_VALC; opb_o = OPB_ZERO; end
      IC_STORE, IC_LOAD: begin opa_o = OPA_VALC; opb_o = OPB_VALB; end
      IC_PUSH, IC_CALL:  begin opa_o = OPA_DEC4; opb_o = OPB_VALB; end
      IC_POP, IC_RET:    begin opa_o = OPA_INC4; opb_o = OPB_VALB; end
      default:           begin opa_o = OPA_ZERO; opb_o = OPB_ZERO; end
    endcase
  end

  always_comb begin
    npc_o = NPC_SEQ;
    case (icode_i)
      IC_JUMP: npc_o = cnd_i ? NPC_VALC : NPC_SEQ;
      IC_CALL: npc_o = NPC_VALC;
      IC_RET:  npc_o = NPC_VALM;
      default: npc_o = NPC_SEQ;
    endcase
  end

endmodule

// File: rtl/regport_select.sv
module regport_select
  import regsel_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int SP_ID = 4
) (
  input  logic [3:0]       icode_i,
  input  logic [REG_W-1:0] ra_i,
  input  logic [REG_W-1:0] rb_i,
  input  logic             cnd_i,
  output logic [REG_W-1:0] src_a_o,
  output logic [REG_W-1:0] src_b_o,
  output logic [REG_W-1:0] dst_e_o,
  output logic [REG_W-1:0] dst_m_o,
  output logic [2:0]       alu_a_sel_o,
  output logic             alu_b_sel_o,
  output logic [1:0]       pc_sel_o
);

  localparam logic [REG_W-1:0] NONE = '1;
  localparam logic [REG_W-1:0] SP   = REG_W'(SP_ID);

  opa_sel_e opa;
  opb_sel_e opb;
  npc_sel_e npc;

  regsel_src #(.REG_W(REG_W), .SP_ID(SP_ID)) u_src (
    .icode_i (icode_i),
    .ra_i    (ra_i),
    .rb_i    (rb_i),
    .src_a_o (src_a_o),
    .src_b_o (src_b_o)
  );

  regsel_dst #(.REG_W(REG_W), .SP_ID(SP_ID)) u_dst (
    .icode_i (icode_i),
    .ra_i    (ra_i),
    .rb_i    (rb_i),
    .cnd_i   (cnd_i),
    .dst_e_o (dst_e_o),
    .dst_m_o (dst_m_o)
  );

  regsel_flow u_flow (
    .icode_i (icode_i),
    .cnd_i   (cnd_i),
    .opa_o   (opa),
    .opb_o   (opb),
    .npc_o   (npc)
  );

  assign alu_a_sel_o = opa;
  assign alu_b_sel_o = opb;
  assign pc_sel_o    = npc;

  // cross-checks between the separately decoded port and select paths
  always_comb begin
    if (npc == NPC_VALM) begin
      p_return_uses_stack_r7: assert (src_a_o == SP && src_b_o == SP && dst_e_o == SP)
        else $error("return target without stack ports");
    end
    if (opa == OPA_INC4 || opa == OPA_DEC4) begin
      p_stack_step_base_r5: assert (src_b_o == SP)
        else $error("stack step with base %0h", src_b_o);
    end
    if (opa == OPA_ZERO && opb == OPB_ZERO) begin
      p_idle_ports_r9: assert (src_a_o == NONE && src_b_o == NONE &&
                               dst_e_o == NONE && dst_m_o == NONE)
        else $error("idle class drives a register port");
    end
    if (opa == OPA_VALC && opb == OPB_VALB) begin
      p_address_base_r4: assert (src_b_o == rb_i && dst_e_o == NONE)
        else $error("address form with wrong ports");
    end
    if (opa == OPA_VALC && opb == OPB_ZERO) begin
      p_immediate_no_reads_r3: assert (src_a_o == NONE && src_b_o == NONE)
        else $error("immediate move reads a register");
    end
  end

endmodule

// File: tb/regport_select_tb.sv
`timescale 1ns/100ps
module regport_select_tb;

  localparam logic [3:0] NO = 4'hF;
  localparam logic [3:0] SPR = 4'h4;

  typedef struct {
    string      tag;
    logic [3:0] ic, ra, rb;
    logic       cnd;
    logic [3:0] sa, sb, de, dm;
    logic [2:0] a;
    logic       b;
    logic [1:0] pc;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] icode = 4'h1;
  logic [3:0] ra = 4'h0;
  logic [3:0] rb = 4'h0;
  logic cnd = 1'b0;
  logic [3:0] src_a, src_b, dst_e, dst_m;
  logic [2:0] alu_a;
  logic       alu_b;
  logic [1:0] pcs;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  regport_select u_dut (
    .icode_i(icode), .ra_i(ra), .rb_i(rb), .cnd_i(cnd),
    .src_a_o(src_a), .src_b_o(src_b), .dst_e_o(dst_e), .dst_m_o(dst_m),
    .alu_a_sel_o(alu_a), .alu_b_sel_o(alu_b), .pc_sel_o(pcs)
  );

  function automatic item_t model(logic [3:0] ic, logic [3:0] a_f, logic [3:0] b_f, logic c);
    item_t e;
    e.ic = ic; e.ra = a_f; e.rb = b_f; e.cnd = c;
    e.sa = NO; e.sb = NO; e.de = NO; e.dm = NO;
    e.a = 3'd4; e.b = 1'b1; e.pc = 2'd0; e.tag = "R9";
    case (ic)
      4'h6: begin e.tag = "R1"; e.sa = a_f; e.sb = b_f; e.de = b_f; e.a = 3'd0; e.b = 1'b0; end
      4'h2: begin e.tag = "R2"; e.sa = a_f; e.de = c ? b_f : NO; e.a = 3'd0; e.b = 1'b1; end
      4'h3: begin e.tag = "R3"; e.de = b_f; e.a = 3'd1; e.b = 1'b1; end
      4'h4: begin e.tag = "R4"; e.sa = a_f; e.sb = b_f; e.a = 3'd1; e.b = 1'b0; end
      4'h5: begin e.tag = "R4"; e.sb = b_f; e.dm = a_f; e.a = 3'd1; e.b = 1'b0; end
      4'hA: begin e.tag = "R5"; e.sa = a_f; e.sb = SPR; e.de = SPR; e.a = 3'd3; e.b = 1'b0; end
      4'h8: begin e.tag = "R5"; e.sb = SPR; e.de = SPR; e.a = 3'd3; e.b = 1'b0; e.pc = 2'd1; end
      4'hB: begin e.tag = "R6"; e.sa = SPR; e.sb = SPR; e.de = (a_f == SPR) ? NO : SPR;
                  e.dm = a_f; e.a = 3'd2; e.b = 1'b0; end
      4'h9: begin e.tag = "R7"; e.sa = SPR; e.sb = SPR; e.de = SPR; e.a = 3'd2; e.b = 1'b0; e.pc = 2'd2; end
      4'h7: begin e.tag = "R8"; e.pc = c ? 2'd1 : 2'd0; end
      default: e.tag = "R9";
    endcase
    return e;
  endfunction

  task automatic compare(item_t e);
    total++;
    if (src_a !== e.sa || src_b !== e.sb || dst_e !== e.de || dst_m !== e.dm ||
        alu_a !== e.a || alu_b !== e.b || pcs !== e.pc) begin
      bad++;
      $display("FAIL %s ic=%h ra=%h rb=%h cnd=%0d: got sa=%h sb=%h de=%h dm=%h a=%0d b=%0d pc=%0d exp sa=%h sb=%h de=%h dm=%h a=%0d b=%0d pc=%0d",
               e.tag, e.ic, e.ra, e.rb, e.cnd, src_a, src_b, dst_e, dst_m, alu_a, alu_b, pcs,
               e.sa, e.sb, e.de, e.dm, e.a, e.b, e.pc);
    end
  endtask

  // driver: apply one instruction just after a rising edge, queue its expectation
  task automatic drive(logic [3:0] ic, logic [3:0] a_f, logic [3:0] b_f, logic c);
    @(posedge clk);
    #1;
    icode = ic; ra = a_f; rb = b_f; cnd = c;
    exp_q.push_back(model(ic, a_f, b_f, c));
  endtask

  // monitor: compare at the falling edge after each drive
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) compare(exp_q.pop_front());
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] ra_set [5];
    logic [3:0] rb_set [4];
    ra_set = '{4'h0, 4'h3, 4'h4, 4'h7, 4'hF};
    rb_set = '{4'h1, 4'h4, 4'h6, 4'hF};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: nop on the inputs, every port idle (R9)
    @(negedge clk);
    compare(model(4'h1, 4'h0, 4'h0, 1'b0));
    // pop naming the stack pointer: loaded value alone goes to register 4 (R6)
    drive(4'hB, SPR, 4'h2, 1'b0);
    // conditional move not taken drops its write (R2); jump taken (R8)
    drive(4'h2, 4'h3, 4'h5, 1'b0);
    drive(4'h2, 4'h3, 4'h5, 1'b1);
    drive(4'h7, 4'h0, 4'h0, 1'b1);
    // full sweep: every class, mixed register fields, both conditions (R1..R9)
    for (int ic = 0; ic < 16; ic++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++)
            drive(4'(ic), ra_set[i], rb_set[j], 1'(c));
    wait (exp_q.size() == 0);
    @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule